// File: doc/BRIEF.md
# Instruction Fetch Endian Adjuster

This unit sits between an instruction fetch stage and the memory port. It accepts a fetch virtual address together with a size selector (32-bit word or 16-bit halfword). It checks the address for alignment and works out the physical address to present to memory. When the returned 64-bit memory element comes back, it picks out the instruction from the correct byte lanes.

Two endian controls shape the byte arithmetic:

- **Reverse-endian mode** flips low bits of the physical address so that a fetch reaches the other half of the memory element.
- **Big-endian CPU mode** flips the byte select that drives the extraction shift.

Both flips use the same pattern. The low three bits are XORed with seven XOR the access code, where the access code is the size in bytes minus one. A misaligned fetch never reaches memory. Instead it completes at once with a fault flag and the offending virtual address.

Each fetch is a single transaction. The caller offers a request with a valid/ready handshake. The unit then issues one memory read with its own valid/ready handshake and waits for the response. It finishes with a one-cycle done strobe, and the instruction or fault is valid during that strobe.

Top module: `fetch_endian_unit`

## Requirements
- R1: A word fetch (fetch_half=0, access code 3) whose virtual address has bit 0 or bit 1 set, or a halfword fetch (fetch_half=1, access code 1) whose virtual address has bit 0 set, completes with done=1 and fault=1 one cycle after acceptance. In that case fault_vaddr equals the virtual address, instr is zero, and mem_req_valid is never raised for that fetch.
- R2: With reverse-endian mode (rev_endian=1) sampled at acceptance, mem_req_addr equals the virtual address with bits [2:0] XORed with 4 for a word fetch and with 6 for a halfword fetch. Bits above bit 2 pass through unchanged.
- R3: With reverse-endian mode off, mem_req_addr equals the virtual address.
- R4: The byte select is virtual address bits [2:0]. When big_cpu=1 was sampled at acceptance, it is XORed with 4 for a word fetch and with 6 for a halfword fetch.
- R5: instr equals mem_rsp_data shifted right by 8 × byte select, truncated to 32 bits for a word fetch. For a halfword fetch it is truncated to 16 bits with instr[31:16] zero.
- R6: An aligned fetch raises mem_req_valid in the cycle after acceptance. mem_req_valid and mem_req_addr hold steady until mem_req_ready is seen, and exactly one memory request is issued per fetch.
- R7: done is a single-cycle pulse. For an aligned fetch it comes in the cycle after mem_rsp_valid is accepted, with fault=0 and the extracted instr.
- R8: fetch_ready is high only when no fetch is in flight and no done is being presented. The size and both endian controls are sampled at acceptance, so later changes to them do not alter the fetch in flight.
- R9: After reset, done=0, fault=0, mem_req_valid=0 and fetch_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch request offered |
| fetch_ready | output | 1 | Unit can accept a fetch |
| fetch_vaddr | input | 32 | Fetch virtual address |
| fetch_half | input | 1 | 0 = word fetch, 1 = halfword fetch |
| rev_endian | input | 1 | Reverse-endian mode |
| big_cpu | input | 1 | Big-endian CPU mode |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Physical read address |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | 64 | Returned memory element |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Misaligned-fetch exception, valid with done |
| fault_vaddr | output | 32 | Faulting virtual address, updated on a fault |
| instr | output | 32 | Extracted instruction, valid with done |

## Verification
Each fetch and its physical address are scored against an independent model, so faults show up at the ports within one fetch:

- A wrong captured mode bit or size shows up at the memory port in the cycle after acceptance, as a physical address differing in bits [2:0].
- A wrong captured byte select shows up only at the done strobe, as an instruction drawn from the wrong byte lanes.
- A stuck or skipped state in the control shows up as a missing, repeated or early done pulse, or as a memory request during a fault. The scoreboard catches this as an unexpected or missing completion.

Mode inputs are flipped while fetches are in flight, to expose any path that reads them live instead of from the values captured at acceptance.

// File: rtl/fetch_adj_pkg.sv
// Package: shared types for the instruction fetch endian adjuster.
// Assumes: one fetch in flight at a time.
package fetch_adj_pkg;

    // Transaction sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } fetch_state_e;

endpackage

// File: rtl/fetch_addr_adjust.sv
// Module: fetch_addr_adjust
// Does:    Combinational alignment check, physical address low-bit flip for
//          reverse-endian mode, and byte select flip for big-endian CPU mode.
// Assumes: Instruction sizes are IW_BYTES (word) and IW_BYTES/2 (halfword);
//          the memory element is EB bytes, a power of two.
module fetch_addr_adjust #(
    parameter int AW       = 32,
    parameter int EB       = 8,
    parameter int IW_BYTES = 4
) (
    input  logic [AW-1:0]         vaddr,
    input  logic                  half,
    input  logic                  rev_endian,
    input  logic                  big_cpu,
    output logic [AW-1:0]         paddr,
    output logic [$clog2(EB)-1:0] byte_sel,
    output logic                  misaligned
);
    localparam int LB = $clog2(EB);
    localparam logic [LB-1:0] MASK      = LB'(EB - 1);
    localparam logic [LB-1:0] CODE_WORD = LB'(IW_BYTES - 1);
    localparam logic [LB-1:0] CODE_HALF = LB'(IW_BYTES / 2 - 1);

    logic [LB-1:0] acc_code;
    logic [LB-1:0] flip;

    // Access code and the flip pattern derived from it.
    always_comb begin
        acc_code = half ? CODE_HALF : CODE_WORD;
        flip     = MASK ^ acc_code;
    end

    // Alignment check, physical address and byte select.
    always_comb begin
        misaligned = (vaddr[LB-1:0] & acc_code) != '0;
        paddr      = {vaddr[AW-1:LB], vaddr[LB-1:0] ^ (rev_endian ? flip : '0)};
        byte_sel   = vaddr[LB-1:0] ^ (big_cpu ? flip : '0);
    end
endmodule

// File: rtl/fetch_extract.sv
// Module: fetch_extract
// Does:    Shifts the memory element right by whole bytes and truncates it to
//          a word or a zero-extended halfword.
// Assumes: DW is a multiple of 8 and at least IW; IW is even.
module fetch_extract #(
    parameter int DW = 64,
    parameter int IW = 32
) (
    input  logic [DW-1:0]           data,
    input  logic [$clog2(DW/8)-1:0] byte_sel,
    input  logic                    half,
    output logic [IW-1:0]           instr
);
    localparam int HW = IW / 2;

    logic [DW-1:0] shifted;

    // Byte-granular right shift.
    always_comb shifted = data >> {byte_sel, 3'b000};

    // Truncate to the selected size, zero-filling the upper half for halfwords.
    always_comb instr = half ? {{(IW-HW){1'b0}}, shifted[HW-1:0]} : shifted[IW-1:0];
endmodule

// File: rtl/fetch_endian_unit.sv
// Module: fetch_endian_unit (top)
// Does:    Accepts a fetch, checks alignment, issues one memory read with an
//          endian-adjusted physical address, and extracts the instruction from
//          the returned element; signals completion with a one-cycle done.
// Assumes: Memory returns exactly one response per accepted request and does
//          not raise mem_rsp_valid before the request is accepted.
module fetch_endian_unit
    import fetch_adj_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 64,
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_valid,
    output logic          fetch_ready,
    input  logic [AW-1:0] fetch_vaddr,
    input  logic          fetch_half,
    input  logic          rev_endian,
    input  logic          big_cpu,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          done,
    output logic          fault,
    output logic [AW-1:0] fault_vaddr,
    output logic [IW-1:0] instr
);
    localparam int EB = DW / 8;
    localparam int LB = $clog2(EB);

    fetch_state_e  state_q;
    logic [AW-1:0] paddr_c, paddr_q;
    logic [LB-1:0] sel_c, sel_q;
    logic          misaligned_c;
    logic          half_q;
    logic          done_q, fault_q;
    logic [AW-1:0] fault_vaddr_q;
    logic [IW-1:0] instr_q, instr_c;
    logic          accept;

    fetch_addr_adjust #(.AW(AW), .EB(EB), .IW_BYTES(IW/8)) u_adjust (
        .vaddr      (fetch_vaddr),
        .half       (fetch_half),
        .rev_endian (rev_endian),
        .big_cpu    (big_cpu),
        .paddr      (paddr_c),
        .byte_sel   (sel_c),
        .misaligned (misaligned_c)
    );

    fetch_extract #(.DW(DW), .IW(IW)) u_extract (
        .data     (mem_rsp_data),
        .byte_sel (sel_q),
        .half     (half_q),
        .instr    (instr_c)
    );

    // Handshake decode at the fetch side.
    always_comb begin
        fetch_ready = (state_q == ST_IDLE) && !done_q;
        accept      = fetch_valid && fetch_ready;
    end

    // Sequencer: accept, issue, wait for response, complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            paddr_q       <= '0;
            sel_q         <= '0;
            half_q        <= 1'b0;
            done_q        <= 1'b0;
            fault_q       <= 1'b0;
            fault_vaddr_q <= '0;
            instr_q       <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    paddr_q <= paddr_c;
                    sel_q   <= sel_c;
                    half_q  <= fetch_half;
                    if (misaligned_c) begin
                        done_q        <= 1'b1;
                        fault_q       <= 1'b1;
                        fault_vaddr_q <= fetch_vaddr;
                        instr_q       <= '0;
                    end else begin
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: if (mem_req_ready) state_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    done_q  <= 1'b1;
                    fault_q <= 1'b0;
                    instr_q <= instr_c;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output drive.
    always_comb begin
        mem_req_valid = (state_q == ST_ISSUE);
        mem_req_addr  = paddr_q;
        done          = done_q;
        fault         = fault_q;
        fault_vaddr   = fault_vaddr_q;
        instr         = instr_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)) // R6
        else $error("request dropped or changed before ready");
    AST_REQ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(fetch_valid && fetch_ready)) // R6
        else $error("memory request without an accepted fetch");
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) // R7
        else $error("done longer than one cycle");
    AST_GOOD_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fault |-> $past(mem_rsp_valid)) // R7
        else $error("completion without a response");
    AST_FAULT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> !$past(mem_req_valid)) // R1
        else $error("fault completion after a memory request");
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !fetch_ready) // R8
        else $error("fetch accepted while busy");
endmodule

// File: tb/fetch_endian_unit_test.sv
`timescale 1ns/1ps
module fetch_endian_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic        fetch_ready;
    logic [31:0] fetch_vaddr = '0;
    logic        fetch_half = 1'b0;
    logic        rev_endian = 1'b0;
    logic        big_cpu = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done;
    logic        fault;
    logic [31:0] fault_vaddr;
    logic [31:0] instr;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    typedef struct {
        logic [31:0] e_instr;
        logic        e_fault;
        logic [31:0] e_fva;
        string       tag;
    } exp_t;
    exp_t sb[$];

    fetch_endian_unit uut (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
        .fetch_vaddr(fetch_vaddr), .fetch_half(fetch_half),
        .rev_endian(rev_endian), .big_cpu(big_cpu),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
        .fault_vaddr(fault_vaddr), .instr(instr)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Independent model of the requirements.
    function automatic logic [2:0] flip_of(input logic half);
        return half ? 3'd6 : 3'd4;
    endfunction

    function automatic logic [31:0] model_paddr(input logic [31:0] v, input logic half, input logic rev);
        return rev ? {v[31:3], v[2:0] ^ flip_of(half)} : v;
    endfunction

    function automatic logic [31:0] model_instr(input logic [63:0] d, input logic [31:0] v,
                                                input logic half, input logic big);
        logic [2:0]  s;
        logic [63:0] sh;
        s  = big ? (v[2:0] ^ flip_of(half)) : v[2:0];
        sh = d >> (8 * s);
        return half ? {16'h0, sh[15:0]} : sh[31:0];
    endfunction

    // Monitor: pop and compare on every done strobe.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check("R7 unexpected done", 64'(done), 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " fault"}, 64'(fault), 64'(e.e_fault));
                check({e.tag, " instr"}, 64'(instr), 64'(e.e_instr));
                if (e.e_fault) check({e.tag, " fault_vaddr"}, 64'(fault_vaddr), 64'(e.e_fva));
            end
        end
    end

    // Driver: one fetch, serving memory with the given stall and latency.
    task automatic do_fetch(input logic [31:0] v, input logic half, input logic rev, input logic big,
                            input logic [63:0] data, input int stall, input int lat, input string tag);
        logic  mis;
        exp_t  e;
        mis = half ? v[0] : (v[1:0] != 2'b00);
        e.e_fault = mis;
        e.e_fva   = v;
        e.e_instr = mis ? 32'h0 : model_instr(data, v, half, big);
        e.tag     = tag;
        sb.push_back(e);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_vaddr = v; fetch_half = half; rev_endian = rev; big_cpu = big;
        while (!fetch_ready) @(negedge clk);
        @(negedge clk);
        fetch_valid = 1'b0;
        if (mis) begin
            check("R1 no memory request on fault", 64'(mem_req_valid), 64'd0);
            return;
        end
        // R8: change controls while the fetch is in flight.
        rev_endian = ~rev; big_cpu = ~big; fetch_half = ~half; fetch_vaddr = ~v;
        check("R6 request raised after accept", 64'(mem_req_valid), 64'd1);
        for (int i = 0; i < stall; i++) begin
            check("R6 request held", 64'(mem_req_valid), 64'd1);
            check({tag, " R2 R3 addr during stall"}, 64'(mem_req_addr), 64'(model_paddr(v, half, rev)));
            @(negedge clk);
        end
        check({tag, " R2 R3 addr"}, 64'(mem_req_addr), 64'(model_paddr(v, half, rev)));
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check("R6 single request", 64'(mem_req_valid), 64'd0);
        for (int i = 0; i < lat; i++) @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_data = data;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = 64'hDEAD_BEEF_0BAD_F00D;
    endtask

    localparam logic [63:0] D0 = 64'h8877_6655_4433_2211;
    localparam logic [63:0] D1 = 64'hF0E1_D2C3_B4A5_9687;

    initial begin
        repeat (3) @(negedge clk);
        check("R9 done after reset", 64'(done), 64'd0);
        check("R9 fault after reset", 64'(fault), 64'd0);
        check("R9 mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 fetch_ready after reset", 64'(fetch_ready), 64'd1);

        do_fetch(32'h0000_1000, 1'b0, 1'b0, 1'b0, D0, 0, 0, "R3 R5 word low");
        do_fetch(32'h0000_1004, 1'b0, 1'b0, 1'b0, D0, 2, 1, "R5 word high");
        do_fetch(32'h0000_1004, 1'b0, 1'b0, 1'b1, D0, 1, 0, "R4 word big");
        do_fetch(32'h0000_1004, 1'b0, 1'b1, 1'b0, D1, 0, 2, "R2 word rev");
        do_fetch(32'hABCD_2000, 1'b0, 1'b1, 1'b1, D1, 3, 1, "R2 R4 word rev big");
        do_fetch(32'h0000_3002, 1'b1, 1'b0, 1'b0, D0, 0, 0, "R5 half lane2");
        do_fetch(32'h0000_3006, 1'b1, 1'b0, 1'b1, D0, 1, 1, "R4 half big");
        do_fetch(32'h0000_3006, 1'b1, 1'b1, 1'b0, D1, 0, 0, "R2 half rev");
        do_fetch(32'h8000_3000, 1'b1, 1'b1, 1'b1, D1, 2, 0, "R2 R4 half rev big");
        do_fetch(32'h0000_1002, 1'b0, 1'b0, 1'b0, D0, 0, 0, "R1 word bit1");
        do_fetch(32'h0000_1003, 1'b0, 1'b1, 1'b1, D0, 0, 0, "R1 word bit0");
        do_fetch(32'h0000_1001, 1'b1, 1'b0, 1'b0, D0, 0, 0, "R1 half bit0");
        do_fetch(32'h0000_100E, 1'b1, 1'b0, 1'b0, D1, 0, 0, "R1 half aligned ok");
        do_fetch(32'h0000_2007, 1'b1, 1'b0, 1'b0, D1, 0, 0, "R1 half after good");
        do_fetch(32'h0000_4004, 1'b0, 1'b0, 1'b0, D1, 0, 0, "R8 R7 after fault");
        repeat (3) @(negedge clk);
        check("R7 all completions seen", 64'(sb.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule